// File: doc/BRIEF.md
# Common-Electrode Polarity Keep-Alive Scheduler

This block keeps a memory-type display's common-electrode drive alternating so that no DC bias can build up inside the panel. It sits beside the serial command transmitter. It holds the polarity bit that the transmitter places in every command header, and it watches the transmitter's command-start strobe. In software polarity mode, each command that starts flips the bit. Ordinary traffic therefore carries the alternation for free.

If no command starts within a programmable window of clock cycles, the block raises a refresh request. The transmitter answers the request by acknowledging it and then sending a short polarity-only command, which is one command byte followed by one zero trailer byte. The window is set well inside the one-second limit the panel tolerates; half a second of system clock is typical. In pin-driven mode the panel takes its polarity from a square wave on a dedicated pin, which this block generates. In that mode the header bit is frozen and no refresh is ever requested.

Top module: `vcom_keeper`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `vbit_o`, `refresh_req_o` and `ext_toggle_o` are all 0.
- R2: In software mode (`ext_mode_i` = 0), a high `cmd_start_i` at a clock edge inverts `vbit_o` at that edge. At every other edge in software mode, `vbit_o` keeps its value.
- R3: In software mode, `refresh_req_o` rises at the edge that completes `DEADLINE_CYC` consecutive cycles without a command start. The count begins after reset, after a command start, or on entry to software mode. It never rises earlier.
- R4: Once raised, `refresh_req_o` stays high until an edge that samples `refresh_ack_i` = 1. After that acknowledge it stays low until a command start restarts the window. It is never re-requested on its own.
- R5: A command start that arrives while a refresh is pending drops `refresh_req_o` at that edge and restarts the window.
- R6: In pin-driven mode (`ext_mode_i` = 1), `vbit_o` holds its value, command starts do not change it, and `refresh_req_o` is 0 from the first edge that samples the mode.
- R7: In pin-driven mode, `ext_toggle_o` inverts after every `EXT_HALF_CYC` edges. The first rise comes `EXT_HALF_CYC` edges after the mode is first sampled high, which gives a period of 2·`EXT_HALF_CYC` cycles.
- R8: In software mode, `ext_toggle_o` is 0 from the first edge that samples the mode. The divider restarts from its low phase the next time pin-driven mode is entered.
- R9: An acknowledge given while `refresh_req_o` is low has no effect: it neither cancels nor delays the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode_i | input | 1 | 0 = polarity from the header bit, 1 = polarity from the toggle pin |
| cmd_start_i | input | 1 | One-cycle strobe from the transmitter as a command byte is loaded |
| refresh_ack_i | input | 1 | Transmitter accepts the pending polarity-only command |
| vbit_o | output | 1 | Polarity bit to place in the command header |
| refresh_req_o | output | 1 | Request for a polarity-only command |
| ext_toggle_o | output | 1 | Square wave for the panel's external polarity pin |

## Verification
In software mode the stimulus sweeps the spacing between command starts through every gap from one cycle to beyond twice the window. This separates traffic that always beats the deadline, traffic that meets it exactly, and traffic that misses it. Acknowledges arrive at different offsets, including before any request exists, which tells an honoured handshake from an ignored one. Other runs leave a request pending and then pre-empt it with a regular command. In pin-driven mode, run lengths are swept across several half-periods and the mode is flipped back and forth. This exposes divider phase errors, polarity leakage into the header bit, and stale requests surviving a mode change.

// File: rtl/vk_pkg.sv
package vk_pkg;

  typedef enum logic {
    VK_SW  = 1'b0,
    VK_EXT = 1'b1
  } vk_mode_e;

  // True on the cycle whose edge completes the idle window.
  function automatic logic idle_window_closing(input int unsigned cnt,
                                               input int unsigned lim);
    return cnt == lim - 1;
  endfunction

  // True on the cycle whose edge completes one half period.
  function automatic logic half_period_closing(input int unsigned cnt,
                                               input int unsigned half);
    return cnt == half - 1;
  endfunction

endpackage

// File: rtl/vk_polarity.sv
module vk_polarity (
  input  logic clk,
  input  logic rst_n,
  input  logic flip_i,
  output logic vbit_o
);

  logic vbit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vbit_q <= 1'b0;
    else if (flip_i) vbit_q <= ~vbit_q;
  end

  assign vbit_o = vbit_q;

endmodule

// File: rtl/vk_deadline.sv
module vk_deadline #(
  parameter int unsigned DEADLINE_CYC = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic start_i,
  input  logic ack_i,
  output logic req_o,
  output logic hit_o
);
  import vk_pkg::*;

  localparam int unsigned CW = $clog2(DEADLINE_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(DEADLINE_CYC);

  logic [CW-1:0] idle_q;
  logic          req_q;
  logic          restart;

  assign restart = !run_i || start_i;
  assign hit_o   = !restart && idle_window_closing(32'(idle_q), DEADLINE_CYC);

  // Idle counter saturates at the limit so a missed deadline is requested once.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            idle_q <= '0;
    else if (restart)      idle_q <= '0;
    else if (idle_q != LIM) idle_q <= idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              req_q <= 1'b0;
    else if (restart)        req_q <= 1'b0;
    else if (req_q && ack_i) req_q <= 1'b0;
    else if (hit_o)          req_q <= 1'b1;
  end

  assign req_o = req_q;

endmodule

// File: rtl/vk_extdiv.sv
module vk_extdiv #(
  parameter int unsigned EXT_HALF_CYC = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tog_o,
  output logic wrap_o
);
  import vk_pkg::*;

  localparam int unsigned DW = (EXT_HALF_CYC > 1) ? $clog2(EXT_HALF_CYC) : 1;

  logic [DW-1:0] div_q;
  logic          tog_q;

  assign wrap_o = en_i && half_period_closing(32'(div_q), EXT_HALF_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      tog_q <= 1'b0;
    end else if (!en_i) begin
      div_q <= '0;
      tog_q <= 1'b0;
    end else if (wrap_o) begin
      div_q <= '0;
      tog_q <= ~tog_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign tog_o = tog_q;

endmodule

// File: rtl/vcom_keeper.sv
module vcom_keeper #(
  parameter int unsigned DEADLINE_CYC = 50_000_000,
  parameter int unsigned EXT_HALF_CYC = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_mode_i,
  input  logic cmd_start_i,
  input  logic refresh_ack_i,
  output logic vbit_o,
  output logic refresh_req_o,
  output logic ext_toggle_o
);
  import vk_pkg::*;

  vk_mode_e mode;
  logic     sw_run;
  logic     flip_evt;
  logic     deadline_hit;
  logic     half_wrap;

  assign mode     = vk_mode_e'(ext_mode_i);
  assign sw_run   = (mode == VK_SW);
  assign flip_evt = sw_run && cmd_start_i;

  vk_polarity u_pol (
    .clk    (clk),
    .rst_n  (rst_n),
    .flip_i (flip_evt),
    .vbit_o (vbit_o)
  );

  vk_deadline #(.DEADLINE_CYC(DEADLINE_CYC)) u_dl (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (sw_run),
    .start_i (cmd_start_i),
    .ack_i   (refresh_ack_i),
    .req_o   (refresh_req_o),
    .hit_o   (deadline_hit)
  );

  vk_extdiv #(.EXT_HALF_CYC(EXT_HALF_CYC)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (!sw_run),
    .tog_o  (ext_toggle_o),
    .wrap_o (half_wrap)
  );

endmodule

// File: rtl/vcom_keeper_chk.sv
module vcom_keeper_chk #(
  parameter int unsigned DEADLINE_CYC = 50_000_000
) (
  input logic clk,
  input logic rst_n,
  input logic ext_mode_i,
  input logic cmd_start_i,
  input logic refresh_ack_i,
  input logic vbit_o,
  input logic refresh_req_o,
  input logic ext_toggle_o,
  input logic deadline_hit,
  input logic half_wrap
);

  localparam int unsigned CW = $clog2(DEADLINE_CYC + 1);

  // Independent idle-cycle tally used to bound the request window.
  logic [CW-1:0] chk_idle;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          chk_idle <= '0;
    else if (ext_mode_i || cmd_start_i)  chk_idle <= '0;
    else if (chk_idle != CW'(DEADLINE_CYC)) chk_idle <= chk_idle + 1'b1;
  end

  p_vbit_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode_i && cmd_start_i) |=> (vbit_o != $past(vbit_o)));

  p_vbit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode_i || !cmd_start_i) |=> $stable(vbit_o));

  p_req_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req_o |-> (chk_idle == CW'(DEADLINE_CYC)));

  p_req_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    deadline_hit |=> refresh_req_o);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req_o && !refresh_ack_i && !cmd_start_i && !ext_mode_i) |=> refresh_req_o);

  p_req_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req_o && refresh_ack_i) |=> !refresh_req_o);

  p_req_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start_i |=> !refresh_req_o);

  p_ext_noreq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode_i |=> !refresh_req_o);

  p_tog_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    half_wrap |=> (ext_toggle_o != $past(ext_toggle_o)));

  p_tog_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode_i |=> !ext_toggle_o);

endmodule

bind vcom_keeper vcom_keeper_chk #(.DEADLINE_CYC(DEADLINE_CYC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ext_mode_i    (ext_mode_i),
  .cmd_start_i   (cmd_start_i),
  .refresh_ack_i (refresh_ack_i),
  .vbit_o        (vbit_o),
  .refresh_req_o (refresh_req_o),
  .ext_toggle_o  (ext_toggle_o),
  .deadline_hit  (deadline_hit),
  .half_wrap     (half_wrap)
);

// File: tb/sim_vcom_keeper.sv
module sim_vcom_keeper;

  localparam int unsigned D = 6;
  localparam int unsigned H = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_mode_i = 1'b0;
  logic cmd_start_i = 1'b0;
  logic refresh_ack_i = 1'b0;
  logic vbit_o, refresh_req_o, ext_toggle_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // bench reference state
  int s_idle = 0;
  bit acked = 1'b0;
  bit req_m = 1'b0;
  bit v_m = 1'b0;
  int e_cnt = 0;
  bit tog_m = 1'b0;

  always #2.5 clk = ~clk;

  vcom_keeper #(.DEADLINE_CYC(D), .EXT_HALF_CYC(H)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .ext_mode_i    (ext_mode_i),
    .cmd_start_i   (cmd_start_i),
    .refresh_ack_i (refresh_ack_i),
    .vbit_o        (vbit_o),
    .refresh_req_o (refresh_req_o),
    .ext_toggle_o  (ext_toggle_o)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One cycle: drive after a falling edge, advance the reference at the
  // rising edge, compare at the next falling edge.
  task automatic step(input bit mode, input bit strobe, input bit ack);
    string vtag, rtag, ttag;
    ext_mode_i = mode;
    cmd_start_i = strobe;
    refresh_ack_i = ack;
    vtag = mode ? "R6" : "R2";
    ttag = mode ? "R7" : "R8";
    if (mode)                  rtag = "R6";
    else if (strobe)           rtag = "R5";
    else if (ack && !req_m)    rtag = "R9";
    else if (req_m || acked)   rtag = "R4";
    else                       rtag = "R3";
    @(posedge clk);
    if (mode) begin
      s_idle = 0; acked = 1'b0; req_m = 1'b0;
      e_cnt++;
      tog_m = ((e_cnt / H) % 2) == 1;
    end else begin
      e_cnt = 0; tog_m = 1'b0;
      if (strobe) begin
        v_m = ~v_m; s_idle = 0; acked = 1'b0; req_m = 1'b0;
      end else begin
        if (req_m && ack) acked = 1'b1;
        if (s_idle < D) s_idle++;
        req_m = (s_idle >= D) && !acked;
      end
    end
    @(negedge clk);
    check(vtag, "vbit", vbit_o, v_m);
    check(rtag, "refresh_req", refresh_req_o, req_m);
    check(ttag, "ext_toggle", ext_toggle_o, tog_m);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    check("R1", "vbit in reset", vbit_o, 1'b0);
    check("R1", "req in reset", refresh_req_o, 1'b0);
    check("R1", "toggle in reset", ext_toggle_o, 1'b0);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0); // R1: first cycle after release, outputs still 0

    // R2 R3 R4 R9: sweep command-start spacing, with acknowledges at varied offsets
    for (int g = 1; g <= 2 * D + 3; g++) begin
      for (int rep = 0; rep < 2; rep++) begin
        for (int i = 0; i < g - 1; i++)
          step(1'b0, 1'b0, (i == 1) || (i == D + (g % 3)));
        step(1'b0, 1'b1, 1'b0);
      end
    end

    // R5: pending request pre-empted by a regular command
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < D + k; i++) step(1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b1, 1'b0);
    end

    // R4: acknowledged request is not re-raised however long the idle stretch
    for (int i = 0; i < D; i++) step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 3 * D; i++) step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0);

    // R6 R7: pin-driven mode with strobes and acknowledges that must be ignored
    for (int i = 0; i < 6 * H + 2; i++) step(1'b1, (i % 2) == 0, (i % 3) == 0);

    // R8 R3: back to software mode, window counts from mode entry
    for (int i = 0; i < D + 3; i++) step(1'b0, 1'b0, 1'b0);

    // R7 R8: sweep pin-driven run lengths so the divider phase restarts each time
    for (int k = 1; k <= 2 * H + 2; k++) begin
      for (int i = 0; i < k; i++) step(1'b1, 1'b1, 1'b0);
      for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 1'b0);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule